// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Half-Bit Stop Control

This block turns bytes into asynchronous serial frames on a single output line. A built-in divider turns the system clock into a tick at sixteen times the bit rate. A bit time is sixteen ticks, and the stop period can be set in half-bit steps. Each frame has these parts, in order:

- a low start bit;
- five to eight data bits, least significant bit first;
- an optional even or odd parity bit;
- a high stop period of zero to three bit times.

Software, or a neighbouring block, writes a byte into a holding register using a valid/ready pair. The byte moves into the shift register at a frame boundary. At that moment a one-cycle empty pulse signals that the next byte may be written. This lets frames run back to back with no idle gap. A break request holds the line low for as long as it stays set. After the break is released, the line returns high for at least one full bit time before any further character.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `wr_ready` is 1 and `empty_irq` is 0.
- R2: One tick occurs every `divisor` clock cycles, and a bit lasts 16 ticks. A `divisor` of 0 or 1 acts as 2. Ticks are never on adjacent cycles.
- R3: A frame is a start bit (0) followed by the data bits, least significant bit first. The number of data bits depends on `word_len`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: `par_mode` controls parity. 01 adds an even parity bit and 10 adds an odd parity bit, each placed right after the data. 00 and 11 add no parity bit.
- R5: `stop_sel` sets a high stop period after the data or parity. The codes give these lengths in ticks: 0 → 0, 1 → 16, 2 → 24, 3 → 32, 4 → 40, 5, 6 and 7 → 48. With two bytes queued, the time from one start edge to the next is the frame bits × 16 + stop ticks, all × the effective divisor, in clocks.
- R6: `wr_ready` is 0 while the holding register is full. A `wr_en` pulse while it is 0 is ignored, and the byte already held is the one sent.
- R7: `empty_irq` pulses for exactly one cycle each time the holding byte moves into the shift register. `wr_ready` is 1 in that same cycle.
- R8: While `brk` is 1 at a frame boundary, and for as long as it stays 1, `txd` is held at 0. After release, `txd` is 1 for at least 16 ticks before the next start bit, even when `stop_sel` is 0.
- R9: `busy` is 1 while a frame, stop period or break is in progress, or while a byte is held. When `busy` is 0, `txd` is 1 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clock cycles per 16x tick |
| word_len | input | 2 | Data bit count code |
| par_mode | input | 2 | Parity select code |
| stop_sel | input | 3 | Stop period code |
| brk | input | 1 | Line break request |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| wr_ready | output | 1 | Holding register is empty |
| empty_irq | output | 1 | One-cycle pulse when the held byte starts sending |
| busy | output | 1 | Transmitter is active or has a byte queued |
| txd | output | 1 | Serial output, idle high |

## Verification
The checker watches some rules on every cycle:

- tick spacing;
- the single-cycle width of the empty pulse, and its agreement with `wr_ready`;
- that `wr_ready` falls only after a write;
- that the line is high and the buffer free whenever the block is idle.

Some behaviour can only be shown by the bench's scenarios, because it depends on the timing of a whole frame:

- the bit order and parity values for each word length;
- the exact frame-to-frame spacing for every stop code and divisor;
- that a write to a full holding register is dropped;
- the length of the break and the recovery time after it.

// File: rtl/async_tx.sv
module async_tx #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       word_len,
  input  logic [1:0]       par_mode,
  input  logic [2:0]       stop_sel,
  input  logic             brk,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             empty_irq,
  output logic             busy,
  output logic             txd
);
  localparam int CW = $clog2(3 * OVS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  function automatic logic [CW-1:0] stop_ticks(input logic [2:0] code);
    case (code)
      3'd0:    stop_ticks = '0;
      3'd1:    stop_ticks = CW'(OVS);
      3'd2:    stop_ticks = CW'(OVS * 3 / 2);
      3'd3:    stop_ticks = CW'(OVS * 2);
      3'd4:    stop_ticks = CW'(OVS * 5 / 2);
      default: stop_ticks = CW'(OVS * 3);
    endcase
  endfunction

  logic [DIV_W-1:0] cnt, lim;
  logic             tick;
  assign lim  = (divisor < DIV_W'(2)) ? DIV_W'(1) : divisor - DIV_W'(1);
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);

  st_t         st, st_n;
  logic [CW-1:0] left, left_n;
  logic [7:0]  hold, sh;
  logic        hold_full;
  logic [2:0]  bitn, last;
  logic [1:0]  f_len;
  logic        f_par_en, f_par_bit;
  logic [CW-1:0] f_stop, brk_stop;
  logic        load, shift, endbits, go;
  logic [7:0]  mask;

  assign last     = {1'b0, f_len} + 3'd4;
  assign brk_stop = (stop_ticks(stop_sel) < CW'(OVS)) ? CW'(OVS) : stop_ticks(stop_sel);
  assign mask     = 8'hFF >> (2'd3 - word_len);

  always_comb begin
    st_n = st; left_n = left; load = 1'b0; shift = 1'b0;
    endbits = 1'b0; go = 1'b0;
    if (tick) begin
      if (left != '0) left_n = left - CW'(1);
      else begin
        case (st)
          S_IDLE:  go = 1'b1;
          S_START: begin st_n = S_DATA; left_n = CW'(OVS - 1); end
          S_DATA:
            if (bitn == last) begin
              if (f_par_en) begin st_n = S_PAR; left_n = CW'(OVS - 1); end
              else endbits = 1'b1;
            end else begin
              shift = 1'b1; left_n = CW'(OVS - 1);
            end
          S_PAR:   endbits = 1'b1;
          S_STOP:  go = 1'b1;
          S_BRK:   if (!brk) begin st_n = S_STOP; left_n = brk_stop - CW'(1); end
          default: st_n = S_IDLE;
        endcase
        if (endbits) begin
          if (f_stop != '0) begin st_n = S_STOP; left_n = f_stop - CW'(1); end
          else go = 1'b1;
        end
        if (go) begin
          if (brk) st_n = S_BRK;
          else if (hold_full) begin st_n = S_START; left_n = CW'(OVS - 1); load = 1'b1; end
          else st_n = S_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; left <= '0; hold <= '0; hold_full <= 1'b0; sh <= '0;
      bitn <= '0; f_len <= '0; f_par_en <= 1'b0; f_par_bit <= 1'b0;
      f_stop <= '0; empty_irq <= 1'b0;
    end else begin
      st <= st_n;
      left <= left_n;
      empty_irq <= load;
      if (wr_en && !hold_full) begin
        hold <= wr_data;
        hold_full <= 1'b1;
      end
      if (load) begin
        hold_full <= 1'b0;
        sh        <= hold;
        bitn      <= '0;
        f_len     <= word_len;
        f_par_en  <= par_mode == 2'b01 || par_mode == 2'b10;
        f_par_bit <= (^(hold & mask)) ^ (par_mode == 2'b10);
        f_stop    <= stop_ticks(stop_sel);
      end else if (shift) begin
        sh   <= sh >> 1;
        bitn <= bitn + 3'd1;
      end
    end

  assign wr_ready = !hold_full;
  assign busy     = (st != S_IDLE) || hold_full;
  assign txd      = (st == S_START || st == S_BRK) ? 1'b0 :
                    (st == S_DATA) ? sh[0] :
                    (st == S_PAR)  ? f_par_bit : 1'b1;
endmodule

module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic txd,
  input logic busy,
  input logic wr_ready,
  input logic wr_en,
  input logic empty_irq
);
  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) empty_irq |=> !empty_irq);
  // R7
  irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) empty_irq |-> wr_ready);
  // R6
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_ready) |-> $past(wr_en));
  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (txd && wr_ready));
endmodule

bind async_tx async_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .busy(busy),
  .wr_ready(wr_ready), .wr_en(wr_en), .empty_irq(empty_irq)
);

// File: tb/async_tx_test.sv
`timescale 1ns/1ps
module async_tx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] divisor = 16'd3;
  logic [1:0] word_len = 2'b11, par_mode = 2'b00;
  logic [2:0] stop_sel = 3'd1;
  logic brk = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, empty_irq, busy, txd;

  int checks = 0, fails = 0;
  int cyc = 0, nf = 0, last_rise = 0, irq_cnt = 0;
  int falls [0:1023];
  logic prev_txd = 1'b1;

  always #2.5 clk = ~clk;

  async_tx uut (.*);

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_txd && !txd) begin falls[nf % 1024] = cyc; nf++; end
      if (!prev_txd && txd) last_rise = cyc;
      if (empty_irq) irq_cnt++;
    end
    prev_txd = txd;
  end

  initial begin
    #(5.0 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_div();
    return (divisor < 2) ? 2 : int'(divisor);
  endfunction

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx_frame(output logic [7:0] d, output logic p, output logic st0);
    int base = nf;
    int per = 16 * eff_div();
    int nb = int'(word_len) + 5;
    d = '0; p = 1'b0;
    while (nf <= base) @(negedge clk);
    repeat (per / 2) @(negedge clk);
    st0 = txd;
    for (int i = 0; i < nb; i++) begin
      repeat (per) @(negedge clk);
      d[i] = txd;
    end
    if (par_mode == 2'b01 || par_mode == 2'b10) begin
      repeat (per) @(negedge clk);
      p = txd;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 busy", busy, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 empty_irq", empty_irq, 0);
  endtask

  task automatic t_frame(input logic [1:0] wl, input logic [1:0] pm, input logic [7:0] d);
    logic [7:0] got, m; logic p, s;
    int irq0 = irq_cnt;
    word_len = wl; par_mode = pm; stop_sel = 3'd1; divisor = 16'd3;
    m = 8'hFF >> (3 - wl);
    fork
      write_byte(d);
      rx_frame(got, p, s);
    join
    chk("R3 start bit", s, 0);
    chk("R3 data bits", got, d & m);
    if (pm == 2'b01 || pm == 2'b10)
      chk("R4 parity bit", p, (^(d & m)) ^ (pm == 2'b10));
    repeat (24) @(negedge clk);
    chk("R5 stop level", txd, 1);
    chk("R9 busy in frame", busy, 1);
    wait_idle();
    chk("R7 one irq per frame", irq_cnt - irq0, 1);
    chk("R9 busy after frame", busy, 0);
  endtask

  task automatic t_stop(input logic [2:0] sc, input logic [15:0] dv);
    int n0, exp_t, st;
    word_len = 2'b11; par_mode = 2'b00; stop_sel = sc; divisor = dv;
    n0 = nf;
    write_byte(8'hFF);
    write_byte(8'hFF);
    while (nf < n0 + 2) @(negedge clk);
    case (sc)
      3'd0: st = 0; 3'd1: st = 16; 3'd2: st = 24; 3'd3: st = 32; 3'd4: st = 40;
      default: st = 48;
    endcase
    exp_t = (9 * 16 + st) * eff_div();
    chk(dv < 2 ? "R2 small divisor spacing" : "R5 frame spacing", falls[(n0 + 1) % 1024] - falls[n0 % 1024], exp_t);
    wait_idle();
  endtask

  task automatic t_buffer();
    logic [7:0] a, b; logic p, s;
    word_len = 2'b11; par_mode = 2'b00; stop_sel = 3'd1; divisor = 16'd2;
    fork
      begin
        write_byte(8'h3C);
        write_byte(8'hA5);
        @(negedge clk);
        chk("R6 ready low when full", wr_ready, 0);
        wr_en = 1'b1; wr_data = 8'h0F;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 still full", wr_ready, 0);
      end
      begin
        rx_frame(a, p, s);
        rx_frame(b, p, s);
      end
    join
    chk("R6 first byte", a, 8'h3C);
    chk("R6 held byte kept", b, 8'hA5);
    wait_idle();
  endtask

  task automatic t_irq();
    int seen = 0, rdy = 1;
    divisor = 16'd4; stop_sel = 3'd1;
    write_byte(8'h81);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (empty_irq) begin seen++; if (!wr_ready) rdy = 0; end
    end
    chk("R7 irq cycles", seen, 1);
    chk("R7 ready with irq", rdy, 1);
    wait_idle();
  endtask

  task automatic t_break();
    int lows = 0, r;
    divisor = 16'd2; stop_sel = 3'd0; word_len = 2'b11; par_mode = 2'b00;
    brk = 1'b1;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R8 line held low", lows, 100);
    write_byte(8'h55);
    repeat (60) @(negedge clk);
    chk("R8 byte waits during break", txd, 0);
    chk("R8 byte held", wr_ready, 0);
    r = nf;
    brk = 1'b0;
    while (nf <= r) @(negedge clk);
    chk("R8 recovery gap", falls[r % 1024] - last_rise, 32);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame(2'b11, 2'b00, 8'hA6);
    t_frame(2'b00, 2'b01, 8'hF3);
    t_frame(2'b10, 2'b10, 8'h35);
    t_frame(2'b01, 2'b01, 8'h2D);
    t_frame(2'b11, 2'b10, 8'h00);
    for (int sc = 0; sc < 8; sc++) t_stop(3'(sc), 16'd3);
    t_stop(3'd2, 16'd5);
    t_stop(3'd1, 16'd0);
    t_stop(3'd1, 16'd1);
    t_buffer();
    t_irq();
    t_break();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule